// File: doc/BRIEF.md
# Horizontal microcoded control sequencer

This block is a small microprogrammed control unit wrapped around a register-transfer datapath. The datapath has three registers: a program counter, a memory address register and a memory data register. An internal control store of 32 words holds the microprogram. In every clock the block reads one wide microinstruction. That word does one register transfer, either a copy or a two-operand add, and it also picks the next micro-address. The next micro-address can be the following word, an explicit target, or a dispatch on the opcode bit of the fetched instruction word.

A read on the memory port starts whenever the address register is written. The data comes back into the data register a fixed two clocks later. The microprogram is scheduled around that delay and never stalls. It contains a two-step boot, a three-step decode stub, a two-step jump routine and a two-step skip routine. Each instruction is two memory words: an opcode word whose bit 0 selects jump (0) or skip (1), followed by an operand word. For a jump, the operand word is the target address.

Top module: `ucode_seq`

## Requirements
- R1: While reset is low at a rising edge, the micro-address, PC, MAR and MDR all clear to 0 and no memory request is raised.
- R2: Sequencer operation NEXT (code 00) makes the next micro-address the current one plus 1.
- R3: Sequencer operation JMP (code 01) loads the micro-address from the word's 5-bit target field; the skip and jump routines end by jumping to the decode entry at micro-address 2.
- R4: Sequencer operation DISP (code 10) loads the target OR'd with MDR bit 0 shifted left by 2; the decode stub at micro-address 4 dispatches with target 8, reaching micro-address 8 (jump routine) for opcode bit 0 and 12 (skip routine) for opcode bit 1.
- R5: ALU operation COPY writes source A to the destination; ADD writes source A plus source B, wrapping at the data width; the constant-one select supplies 1.
- R6: Destination NONE leaves PC, MAR and MDR unchanged.
- R7: Every MAR write raises mem_req_o for the next cycle with mem_addr_o equal to the new MAR, and MDR takes mem_rdata_i on the edge after mem_rvalid_i is sampled high, so a word lands in MDR two edges after its MAR write.
- R8: Two edges after reset is released the decode entry is reached with MAR = 0 and PC = 1.
- R9: On entry to decode at opcode address A, MAR = A and PC = A + 1; the decode stub sets MAR = A + 1 at micro-address 3 and PC = A + 2 at micro-address 4.
- R10: A jump instruction at A sets MAR to the operand word T at micro-address 9 and re-enters decode with MAR = T and PC = T + 1.
- R11: A skip instruction at A ignores its operand and re-enters decode with MAR = A + 2 and PC = A + 3.
- R12: Every instruction, jump or skip, takes exactly 5 clocks from decode entry to the next decode entry, with no stall on memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rvalid_i | input | 1 | Read data from memory is valid this cycle |
| mem_rdata_i | input | DW | Read data from memory |
| mem_req_o | output | 1 | Read request, high in the cycle after a MAR write |
| mem_addr_o | output | DW | Memory address (current MAR) |
| pc_o | output | DW | Program counter |
| mdr_o | output | DW | Memory data register |
| upc_o | output | 5 | Current micro-address |

## Verification
The bench checks the latency overlap. If the design fetched MDR one edge early or late, the jump routine would copy the opcode word instead of the operand into MAR, and execution would run off to the wrong address. It also runs address wrap at the top of memory: a jump to 255 is followed by a skip that has to carry PC past 0 to reach address 1. It runs a self-jump loop, which only leaves once memory is rewritten, and so it catches a design that caches or reorders operand reads. Dispatch on both opcode values, and the lack of any register change during the dispatch step, catch a wrong shift in the dispatch target or writes that leak through when the destination is NONE.

// File: rtl/ucode_pkg.sv
// Package: shared encodings and the microprogram for the control sequencer.
// Assumes a 5-bit micro-address; the control store is computed by a function.
package ucode_pkg;

    localparam int UA_W       = 5;
    localparam int DISP_SHIFT = 2;
    localparam logic [UA_W-1:0] UA_BOOT = 5'd0;
    localparam logic [UA_W-1:0] UA_DEC  = 5'd2;
    localparam logic [UA_W-1:0] UA_DSP  = 5'd4;
    localparam logic [UA_W-1:0] UA_BASE = 5'd8;
    localparam logic [UA_W-1:0] UA_JMP  = 5'd8;
    localparam logic [UA_W-1:0] UA_SKP  = 5'd12;

    typedef enum logic [1:0] {SEL_PC = 2'b00, SEL_MAR = 2'b01, SEL_MDR = 2'b10, SEL_ONE = 2'b11} src_e;
    typedef enum logic [1:0] {DST_PC = 2'b00, DST_MAR = 2'b01, DST_MDR = 2'b10, DST_NONE = 2'b11} dst_e;
    typedef enum logic       {ALU_COPY = 1'b0, ALU_ADD = 1'b1} alu_e;
    typedef enum logic [1:0] {SEQ_NEXT = 2'b00, SEQ_JMP = 2'b01, SEQ_DISP = 2'b10, SEQ_RSVD = 2'b11} seq_e;

    typedef struct packed {
        src_e              a;
        src_e              b;
        dst_e              dst;
        alu_e              alu;
        seq_e              seq;
        logic [UA_W-1:0]   tgt;
    } uword_t;

    // Build one microinstruction from its fields.
    function automatic uword_t mk(src_e a, src_e b, dst_e d, alu_e op, seq_e s, logic [UA_W-1:0] t);
        uword_t w;
        w.a = a; w.b = b; w.dst = d; w.alu = op; w.seq = s; w.tgt = t;
        return w;
    endfunction

    // Control store contents, one word per micro-address.
    function automatic uword_t rom_fetch(logic [UA_W-1:0] ua);
        uword_t w;
        case (ua)
            5'd0:    w = mk(SEL_PC,  SEL_ONE, DST_MAR,  ALU_COPY, SEQ_NEXT, '0);      // boot: fetch word 0
            5'd1:    w = mk(SEL_PC,  SEL_ONE, DST_PC,   ALU_ADD,  SEQ_JMP,  UA_DEC);  // boot: PC past opcode
            5'd2:    w = mk(SEL_PC,  SEL_ONE, DST_MAR,  ALU_COPY, SEQ_NEXT, '0);      // decode: fetch operand
            5'd3:    w = mk(SEL_PC,  SEL_ONE, DST_PC,   ALU_ADD,  SEQ_NEXT, '0);      // decode: PC past operand
            5'd4:    w = mk(SEL_PC,  SEL_ONE, DST_NONE, ALU_COPY, SEQ_DISP, UA_BASE); // decode: dispatch
            5'd8:    w = mk(SEL_MDR, SEL_ONE, DST_MAR,  ALU_COPY, SEQ_NEXT, '0);      // jump: target to MAR
            5'd9:    w = mk(SEL_MAR, SEL_ONE, DST_PC,   ALU_ADD,  SEQ_JMP,  UA_DEC);  // jump: PC = target + 1
            5'd12:   w = mk(SEL_PC,  SEL_ONE, DST_MAR,  ALU_COPY, SEQ_NEXT, '0);      // skip: next opcode
            5'd13:   w = mk(SEL_PC,  SEL_ONE, DST_PC,   ALU_ADD,  SEQ_JMP,  UA_DEC);  // skip: PC past opcode
            default: w = mk(SEL_PC,  SEL_ONE, DST_NONE, ALU_COPY, SEQ_JMP,  UA_DEC);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ucode_store.sv
// Control store: combinational read of the microprogram at the current micro-address.
// Assumes the contents come from ucode_pkg::rom_fetch.
module ucode_store
    import ucode_pkg::*;
#(
    parameter int AW = UA_W
) (
    input  logic [AW-1:0] ua_i,
    output uword_t        uw_o
);

    // Look up the word for the current micro-address.
    always_comb uw_o = rom_fetch(ua_i);

endmodule

// File: rtl/ucode_useq.sv
// Micro-address sequencer: step, jump or opcode dispatch, one update per clock.
// Assumes the opcode bit is valid in MDR during the dispatch cycle.
module ucode_useq
    import ucode_pkg::*;
#(
    parameter int AW    = UA_W,
    parameter int SHIFT = DISP_SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_e          seq_i,
    input  logic [AW-1:0] tgt_i,
    input  logic          opc_i,
    output logic [AW-1:0] ua_o
);

    logic [AW-1:0] ua_nxt;

    // Choose the next micro-address from the sequencer operation.
    always_comb begin
        case (seq_i)
            SEQ_NEXT: ua_nxt = ua_o + 1'b1;
            SEQ_JMP:  ua_nxt = tgt_i;
            SEQ_DISP: ua_nxt = tgt_i | (AW'(opc_i) << SHIFT);
            default:  ua_nxt = tgt_i;
        endcase
    end

    // Micro-address register, cleared to the boot entry.
    always_ff @(posedge clk) begin
        if (!rst_n) ua_o <= UA_BOOT;
        else        ua_o <= ua_nxt;
    end

endmodule

// File: rtl/ucode_dpath.sv
// Register-transfer datapath: PC, MAR, MDR with a copy/add unit and a read launch.
// Assumes memory returns data two edges after the MAR write, reported by rvalid.
module ucode_dpath
    import ucode_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  src_e          src_a_i,
    input  src_e          src_b_i,
    input  dst_e          dst_i,
    input  alu_e          alu_i,
    input  logic          mem_rvalid_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic [DW-1:0] pc_o,
    output logic [DW-1:0] mar_o,
    output logic [DW-1:0] mdr_o,
    output logic          mem_req_o
);

    localparam int NREG    = 3;
    localparam int MDR_IDX = 2;

    logic [DW-1:0] opa, opb, res;
    logic [DW-1:0] regs [NREG];

    // Map an operand select to its value.
    function automatic logic [DW-1:0] pick(src_e s, logic [DW-1:0] p, logic [DW-1:0] m, logic [DW-1:0] d);
        case (s)
            SEL_PC:  return p;
            SEL_MAR: return m;
            SEL_MDR: return d;
            default: return DW'(1);
        endcase
    endfunction

    // Operand selection and the copy/add result.
    always_comb begin
        opa = pick(src_a_i, pc_o, mar_o, mdr_o);
        opb = pick(src_b_i, pc_o, mar_o, mdr_o);
        res = (alu_i == ALU_ADD) ? opa + opb : opa;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam dst_e MINE = dst_e'(g);
        logic [DW-1:0] q;
        if (g == MDR_IDX) begin : g_mdr
            // Data register: memory return has priority over a transfer.
            always_ff @(posedge clk) begin
                if (!rst_n)            q <= '0;
                else if (mem_rvalid_i) q <= mem_rdata_i;
                else if (dst_i == MINE) q <= res;
            end
        end else begin : g_plain
            // Address or program counter register written by a transfer.
            always_ff @(posedge clk) begin
                if (!rst_n)             q <= '0;
                else if (dst_i == MINE) q <= res;
            end
        end
        assign regs[g] = q;
    end

    assign pc_o  = regs[0];
    assign mar_o = regs[1];
    assign mdr_o = regs[MDR_IDX];

    // Launch a read in the cycle after every address register write.
    always_ff @(posedge clk) begin
        if (!rst_n) mem_req_o <= 1'b0;
        else        mem_req_o <= (dst_i == DST_MAR);
    end

endmodule

// File: rtl/ucode_seq.sv
// Top: horizontal microcoded sequencer joining control store, sequencer and datapath.
// Assumes a fixed two-edge memory read latency; the microprogram never stalls.
module ucode_seq
    import ucode_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mem_rvalid_i,
    input  logic [DW-1:0]               mem_rdata_i,
    output logic                        mem_req_o,
    output logic [DW-1:0]               mem_addr_o,
    output logic [DW-1:0]               pc_o,
    output logic [DW-1:0]               mdr_o,
    output logic [ucode_pkg::UA_W-1:0]  upc_o
);

    localparam int OPC_BIT = 0;

    uword_t        uw;
    logic [DW-1:0] mar;

    ucode_store #(.AW(UA_W)) store_i (
        .ua_i (upc_o),
        .uw_o (uw)
    );

    ucode_useq #(.AW(UA_W), .SHIFT(DISP_SHIFT)) useq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .seq_i (uw.seq),
        .tgt_i (uw.tgt),
        .opc_i (mdr_o[OPC_BIT]),
        .ua_o  (upc_o)
    );

    ucode_dpath #(.DW(DW)) dpath_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_a_i      (uw.a),
        .src_b_i      (uw.b),
        .dst_i        (uw.dst),
        .alu_i        (uw.alu),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .pc_o         (pc_o),
        .mar_o        (mar),
        .mdr_o        (mdr_o),
        .mem_req_o    (mem_req_o)
    );

    assign mem_addr_o = mar;

endmodule

// File: rtl/ucode_seq_chk.sv
// Checker for ucode_seq: relates the microword to the following state.
// Assumes it is bound into ucode_seq and sees its internal microword.
module ucode_seq_chk
    import ucode_pkg::*;
#(
    parameter int DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input uword_t          uw,
    input logic [UA_W-1:0] upc,
    input logic [DW-1:0]   pc,
    input logic [DW-1:0]   mar,
    input logic [DW-1:0]   mdr,
    input logic            mem_req,
    input logic            mem_rvalid,
    input logic [DW-1:0]   mem_rdata
);

    logic saw_rst;

    // Remember that a reset edge has occurred.
    always_ff @(posedge clk) saw_rst <= !rst_n;

    // Reset state checked mid-cycle after a reset edge.
    always @(negedge clk) begin
        if (saw_rst && !rst_n) begin
            // R1
            reset_state_chk: assert (upc == '0 && pc == '0 && mar == '0 && mdr == '0 && !mem_req)
                else $error("reset state wrong");
        end
    end

    // R2
    seq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.seq == SEQ_NEXT) |=> (upc == UA_W'($past(upc) + 1'b1)));

    // R3
    seq_jmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.seq == SEQ_JMP) |=> (upc == $past(uw.tgt)));

    // R4
    seq_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.seq == SEQ_DISP) |=> (upc == ($past(uw.tgt) | (UA_W'($past(mdr[0])) << DISP_SHIFT))));

    // R5
    pc_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.dst == DST_PC && uw.alu == ALU_ADD && uw.a == SEL_PC && uw.b == SEL_ONE)
        |=> (pc == DW'($past(pc) + 1'b1)));

    // R6
    dst_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.dst == DST_NONE) |=> ($stable(pc) && $stable(mar)));

    // R7
    req_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uw.dst == DST_MAR) |=> mem_req);

    // R7
    mdr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |=> (mdr == $past(mem_rdata)));

endmodule

bind ucode_seq ucode_seq_chk #(.DW(DW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .uw         (uw),
    .upc        (upc_o),
    .pc         (pc_o),
    .mar        (mem_addr_o),
    .mdr        (mdr_o),
    .mem_req    (mem_req_o),
    .mem_rvalid (mem_rvalid_i),
    .mem_rdata  (mem_rdata_i)
);

// File: tb/ucode_seq_tb.sv
// Bench: two-edge memory model, directed program head, then a random program.
module ucode_seq_tb_top;

    localparam int DW     = 8;
    localparam int UAW    = 5;
    localparam int CLK_NS = 10;
    localparam int NINSTR = 60;
    localparam int MSIZE  = 1 << DW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mem_rvalid = 1'b0;
    logic [DW-1:0]  mem_rdata = '0;
    logic           mem_req;
    logic [DW-1:0]  mem_addr;
    logic [DW-1:0]  pc;
    logic [DW-1:0]  mdr;
    logic [UAW-1:0] upc;

    logic [DW-1:0]  mem [MSIZE];
    int             checks = 0;
    int             errors = 0;
    int             cyc = 0;
    bit             done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    ucode_seq #(.DW(DW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .pc_o         (pc),
        .mdr_o        (mdr),
        .upc_o        (upc)
    );

    // Memory model: one registered stage after the request cycle.
    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr];
        cyc        <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Address of the next opcode after the instruction at a.
    function automatic logic [DW-1:0] exp_next(input logic [DW-1:0] a);
        if (mem[a][0]) return DW'(a + 2);
        return mem[DW'(a + 1)];
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        #(CLK_NS * 150000);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        summary();
    end

    initial begin
        logic [DW-1:0] a;
        logic [DW-1:0] nxt;
        int            last;
        int            visits3;
        bit            lost;
        void'($urandom(32'h5eed));
        for (int i = 0; i < MSIZE; i++) mem[i] = DW'($urandom);
        mem[0]   = 8'h02;  // jump to 255
        mem[1]   = 8'hFF;  // operand; also a skip opcode when reached
        mem[255] = 8'h01;  // skip, PC wraps through 0
        mem[3]   = 8'h00;  // self jump
        mem[4]   = 8'h03;
        visits3  = 0;
        lost     = 1'b0;

        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk(upc == 0 && pc == 0 && mem_addr == 0 && mdr == 0 && !mem_req, "R1", int'(upc), 0);
        rst_n = 1'b1;
        last = cyc;
        @(negedge clk);
        chk(mem_req == 1'b1 && mem_addr == 0, "R7", int'(mem_req), 1);
        @(negedge clk);
        // R8: decode entry two edges after release
        chk(upc == 2 && cyc - last == 2, "R8", int'(upc), 2);
        chk(mem_addr == 0 && pc == 1, "R8", int'(pc), 1);

        a = '0;
        for (int n = 0; n < NINSTR && !lost; n++) begin
            if (n > 0) begin
                for (int w = 0; w < 12 && upc != 2; w++) @(negedge clk);
                chk(upc == 2, "R3", int'(upc), 2);
                if (upc != 2) lost = 1'b1;
                // R12: fixed instruction period
                chk(cyc - last == 5, "R12", cyc - last, 5);
            end
            last = cyc;
            if (a == 3) begin
                visits3++;
                if (visits3 == 2) mem[4] = 8'h40;
            end
            nxt = exp_next(a);
            // R9: decode entry invariant
            chk(mem_addr == a && pc == DW'(a + 1), "R9", int'(mem_addr), int'(a));
            @(negedge clk);
            chk(upc == 3, "R2", int'(upc), 3);
            chk(mem_addr == DW'(a + 1), "R5", int'(mem_addr), int'(DW'(a + 1)));
            @(negedge clk);
            chk(pc == DW'(a + 2), "R5", int'(pc), int'(DW'(a + 2)));
            chk(mdr == mem[a], "R7", int'(mdr), int'(mem[a]));
            @(negedge clk);
            // R4: dispatch on opcode bit 0
            chk(upc == (mem[a][0] ? 12 : 8), "R4", int'(upc), mem[a][0] ? 12 : 8);
            // R6: dispatch step leaves PC and MAR alone
            chk(pc == DW'(a + 2) && mem_addr == DW'(a + 1), "R6", int'(pc), int'(DW'(a + 2)));
            chk(mdr == mem[DW'(a + 1)], "R7", int'(mdr), int'(mem[DW'(a + 1)]));
            @(negedge clk);
            if (mem[a][0]) begin
                chk(upc == 13, "R2", int'(upc), 13);
                chk(mem_addr == DW'(a + 2), "R11", int'(mem_addr), int'(DW'(a + 2)));
            end else begin
                chk(upc == 9, "R2", int'(upc), 9);
                chk(mem_addr == nxt, "R10", int'(mem_addr), int'(nxt));
            end
            @(negedge clk);
            chk(mem_addr == nxt && pc == DW'(nxt + 1), mem[a][0] ? "R11" : "R10", int'(pc), int'(DW'(nxt + 1)));
            a = nxt;
        end
        chk(visits3 >= 2, "R10", visits3, 2);
        summary();
    end

endmodule